// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host-side controller for a three-wire serial sampling converter. It makes the convert strobe and a burst of serial clocks from the system clock. It shifts the returned result word in from the converter's data line and presents it as a parallel word with a one-cycle valid strobe. The word width is 12 or 14 bits, set by a parameter. The strobe's position inside the frame and the frame length are also parameters, so the sample rate follows from the frame length.

A frame begins with the convert strobe rising while the serial clock is low. Half a serial clock period later the first serial clock rising edge follows. The frame then runs for `FRAME_CLKS` rising edges: 16 of them carry the data window and the rest give the converter time to acquire. A single `start_i` pulse runs one frame. Holding `cont_i` high chains frames back to back. Each word the converter sends describes the sample it took at the previous convert strobe, so the first word after reset is marked as carrying no real sample.

Top module: `sadc_reader`

## Requirements
- R1: Out of reset, and whenever no frame is running, `conv_o`, `sck_o`, `busy_o` and `valid_o` are low, and `data_o` is zero after reset.
- R2: A `start_i` pulse while idle starts a frame. `conv_o` rises while `sck_o` is low, and the first `sck_o` rising edge comes `HALF_DIV` clock cycles later.
- R3: `conv_o` stays high for exactly one serial clock period, which is one `sck_o` rising edge while it is high. It falls on the next `sck_o` falling edge.
- R4: Every frame has exactly `FRAME_CLKS` rising edges on `sck_o`. `busy_o` stays high for the whole frame and drops on the falling edge after the last rise.
- R5: `sdo_i` is sampled on `sck_o` rising edges `MSB_CLK` through `MSB_CLK+RES_BITS-1`, counting from 1 at the first rise after `conv_o` rises. The bit sampled first lands in `data_o[RES_BITS-1]` and the last one in `data_o[0]`.
- R6: With `RES_BITS`=12, the bits sampled on the rises after the last data bit (the two trailing don't-care periods of the 16-clock window) have no effect on `data_o`.
- R7: `valid_o` is a one-cycle pulse. It is high in the cycle after the clock edge that makes `sck_o` rising edge `MSB_CLK+RES_BITS-1`. Each frame gives exactly one pulse, and `data_o` holds between pulses.
- R8: `fresh_o`, read together with `valid_o`, is low for the first word after reset and high for every later word.
- R9: If `cont_i` is high when a frame's last `sck_o` falling edge occurs, `conv_o` rises on that same edge. The next frame follows with no gap, `FRAME_CLKS` rises after the previous strobe.
- R10: A `start_i` pulse while `busy_o` is high is ignored: no extra frame is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse to run one frame from idle |
| cont_i | input | 1 | Level; keeps frames running back to back |
| sdo_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Serial clock to the converter, idle low |
| busy_o | output | 1 | High while a frame is running |
| data_o | output | RES_BITS | Last captured result word |
| valid_o | output | 1 | One-cycle strobe for a new `data_o` |
| fresh_o | output | 1 | Word carries a real prior sample |

## Verification
The convert strobe comes out one cycle after the accepted `start_i`. The first serial rise follows `HALF_DIV` cycles after that. A result word appears one cycle after the edge that makes rise `MSB_CLK+RES_BITS-1`. The bench samples every output on the falling clock edge and counts serial rises itself from the visible `sck_o`. It therefore checks each strobe against the rise index where it is due, not against a fixed delay. The converter model changes `sdo_i` just after each serial rise, so the data checks also show the bit that was captured on that rise.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;

  function automatic int unsigned last_bit_clk(int unsigned msb_clk, int unsigned res);
    return msb_clk + res - 1;
  endfunction
endpackage

// File: rtl/sadc_sck_gen.sv
module sadc_sck_gen #(
  parameter int unsigned HALF_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == CNT_LAST);
  assign rise_o = wrap && !sck_o;
  assign fall_o = wrap && sck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sck_o <= ~sck_o;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq
  import sadc_pkg::*;
#(
  parameter int unsigned FRAME_CLKS = 18,
  parameter int unsigned IDX_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             run_o,
  output logic             conv_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_CLKS);

  phase_e ph_q;
  assign run_o = (ph_q == PH_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      conv_o <= 1'b0;
      idx_o  <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (start_i || cont_i) begin
        ph_q   <= PH_RUN;
        conv_o <= 1'b1;
        idx_o  <= '0;
      end
    end else begin
      if (rise_i) idx_o <= idx_o + IDX_W'(1);
      if (fall_i) begin
        if (idx_o == IDX_ONE) conv_o <= 1'b0;
        if (idx_o == IDX_LAST) begin
          if (cont_i) begin
            conv_o <= 1'b1;  // chained frame: strobe on this falling edge
            idx_o  <= '0;
          end else begin
            ph_q <= PH_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int unsigned RES_BITS = 14,
  parameter int unsigned MSB_CLK  = 3,
  parameter int unsigned IDX_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                sdo_i,
  output logic [RES_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                fresh_o
);
  localparam int unsigned LAST_CLK = sadc_pkg::last_bit_clk(MSB_CLK, RES_BITS);

  logic [IDX_W-1:0]    k;
  logic                in_win, at_last, primed_q;
  logic [RES_BITS-1:0] sh_q, nxt;

  assign k       = idx_i + IDX_W'(1);  // index of the rise now happening
  assign in_win  = rise_i && (k >= IDX_W'(MSB_CLK)) && (k <= IDX_W'(LAST_CLK));
  assign at_last = rise_i && (k == IDX_W'(LAST_CLK));
  assign nxt     = {sh_q[RES_BITS-2:0], sdo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      data_o   <= '0;
      valid_o  <= 1'b0;
      fresh_o  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      valid_o <= at_last;
      if (in_win) sh_q <= nxt;
      if (at_last) begin
        data_o   <= nxt;
        fresh_o  <= primed_q;
        primed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader #(
  parameter int unsigned RES_BITS   = 14,
  parameter int unsigned FRAME_CLKS = 18,
  parameter int unsigned MSB_CLK    = 3,
  parameter int unsigned HALF_DIV   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                cont_i,
  input  logic                sdo_i,
  output logic                conv_o,
  output logic                sck_o,
  output logic                busy_o,
  output logic [RES_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                fresh_o
);
  localparam int unsigned IDX_W = $clog2(FRAME_CLKS + 2);

  logic             run, rise, fall;
  logic [IDX_W-1:0] idx;

  sadc_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .sck_o (sck_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  sadc_frame_seq #(.FRAME_CLKS(FRAME_CLKS), .IDX_W(IDX_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .cont_i (cont_i),
    .rise_i (rise),
    .fall_i (fall),
    .run_o  (run),
    .conv_o (conv_o),
    .idx_o  (idx)
  );

  sadc_capture #(.RES_BITS(RES_BITS), .MSB_CLK(MSB_CLK), .IDX_W(IDX_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .idx_i  (idx),
    .sdo_i  (sdo_i),
    .data_o (data_o),
    .valid_o(valid_o),
    .fresh_o(fresh_o)
  );

  assign busy_o = run;
endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk #(
  parameter int unsigned RES_BITS   = 14,
  parameter int unsigned FRAME_CLKS = 18,
  parameter int unsigned MSB_CLK    = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic conv_o,
  input logic sck_o,
  input logic busy_o,
  input logic valid_o,
  input logic fresh_o
);
  localparam logic [15:0] N_FRAME  = 16'(FRAME_CLKS);
  localparam logic [15:0] N_BEFORE = 16'(MSB_CLK + RES_BITS - 2);

  logic        sck_q, conv_q, primed_q;
  logic [15:0] rcnt_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      conv_q   <= 1'b0;
      primed_q <= 1'b0;
      rcnt_q   <= '0;
      hi_q     <= '0;
    end else begin
      sck_q  <= sck_o;
      conv_q <= conv_o;
      if (valid_o) primed_q <= 1'b1;
      if (conv_o && !conv_q) begin
        rcnt_q <= '0;
        hi_q   <= '0;
      end else if (sck_o && !sck_q) begin
        rcnt_q <= rcnt_q + 16'd1;
        if (conv_o) hi_q <= hi_q + 16'd1;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sck_o && !conv_o));  // R1
  AST_CONV_LEADS_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> !sck_o);  // R2
  AST_CONV_ONE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(conv_o) |-> (hi_q == 16'd1));  // R3
  AST_FRAME_CLKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (rcnt_q == N_FRAME));  // R4
  AST_VALID_AT_LAST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($rose(sck_o) && rcnt_q == N_BEFORE));  // R7
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R7
  AST_FIRST_STALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !primed_q) |-> !fresh_o);  // R8
  AST_LATER_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && primed_q) |-> fresh_o);  // R8
  AST_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(conv_o) && $past(busy_o)) |-> (rcnt_q == N_FRAME));  // R9
endmodule

bind sadc_reader sadc_reader_chk #(
  .RES_BITS  (RES_BITS),
  .FRAME_CLKS(FRAME_CLKS),
  .MSB_CLK   (MSB_CLK)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .conv_o (conv_o),
  .sck_o  (sck_o),
  .busy_o (busy_o),
  .valid_o(valid_o),
  .fresh_o(fresh_o)
);

// File: tb/sadc_reader_env.sv
module sadc_reader_env #(
  parameter int unsigned RES_BITS = 14
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   errors,
  output logic done
);
  localparam int FRAME = 18;
  localparam int MSB   = 3;
  localparam int HALF  = 1;
  localparam int LAST  = MSB + RES_BITS - 1;

  logic start, cont, sdo;
  logic conv, sck, busy, valid, fresh;
  logic [RES_BITS-1:0] data;

  sadc_reader #(.RES_BITS(RES_BITS), .FRAME_CLKS(FRAME), .MSB_CLK(MSB), .HALF_DIV(HALF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont), .sdo_i(sdo),
    .conv_o(conv), .sck_o(sck), .busy_o(busy), .data_o(data), .valid_o(valid), .fresh_o(fresh)
  );

  typedef struct {logic [RES_BITS-1:0] d; bit fr;} exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL [%0d-bit] %s: actual %0h expected %0h", RES_BITS, req, act, exp);
    end
  endtask

  function automatic logic [RES_BITS-1:0] analog(int n);
    logic [31:0] v;
    case (n % 4)
      0:       v = '1;
      1:       v = '0;
      2:       v = 32'h5555_5555;
      default: v = (n * 32'h0000_9E37) ^ 32'h0000_3C5A;
    endcase
    return v[RES_BITS-1:0];
  endfunction

  // converter model: each word is the sample held at the previous strobe
  logic [RES_BITS-1:0] held = '0, tx = '0;
  int conv_n = 0, sck_n = 0;

  always @(posedge conv) begin
    tx = held;
    held = analog(conv_n);
    q.push_back('{tx, conv_n > 0});
    conv_n++;
    sck_n = 0;
  end

  always @(posedge sck) begin
    sck_n++;
    #1;
    if (sck_n >= MSB - 1 && sck_n <= LAST - 1) sdo = tx[RES_BITS - 1 - (sck_n - (MSB - 1))];
    else sdo = 1'b1;  // don't-care periods driven high
  end

  // monitor / scoreboard
  logic vprev = 0, cprev = 0, sprev = 0, bprev = 0;
  int mon_r = 0, hi_r = 0, lead = 0, n_conv = 0;
  bit measuring = 0;
  exp_t e;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        chk(!vprev, "R7", vprev, 0);
        if (q.size() == 0) chk(0, "R7", 1, 0);
        else begin
          e = q.pop_front();
          if (LAST < 16) chk(data === e.d, "R6", data, e.d);
          else chk(data === e.d, "R5", data, e.d);
          chk(fresh === e.fr, "R8", fresh, e.fr);
          chk(sck_n == LAST, "R7", sck_n, LAST);
        end
      end
      if (measuring) lead++;
      if (sck && !sprev) begin
        mon_r++;
        if (conv) hi_r++;
        if (measuring) begin
          chk(lead == HALF, "R2", lead, HALF);
          measuring = 0;
        end
      end
      if (conv && !cprev) begin
        chk(!sck, "R2", sck, 0);
        if (bprev) chk(mon_r == FRAME, "R9", mon_r, FRAME);
        mon_r = 0; hi_r = 0; lead = 0; measuring = 1;
        n_conv++;
      end
      if (!conv && cprev) chk(hi_r == 1, "R3", hi_r, 1);
      if (!busy && bprev) chk(mon_r == FRAME, "R4", mon_r, FRAME);
    end
    vprev = valid; cprev = conv; sprev = sck; bprev = busy;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  initial begin
    bit bad;
    int base;
    checks = 0; errors = 0; done = 0;
    start = 0; cont = 0; sdo = 1'bz;
    wait (rst_n);
    @(negedge clk);
    chk(conv == 0, "R1", conv, 0);
    chk(sck == 0, "R1", sck, 0);
    chk(busy == 0, "R1", busy, 0);
    chk(valid == 0, "R1", valid, 0);
    chk(data == 0, "R1", data, 0);
    // single frame
    pulse_start();
    wait_idle();
    chk(n_conv == 1, "R2", n_conv, 1);
    // idle stays quiet
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (sck || conv || valid || busy) bad = 1;
    end
    chk(!bad, "R1", bad, 0);
    // start during busy is ignored
    pulse_start();
    repeat (5) @(negedge clk);
    chk(busy == 1, "R10", busy, 1);
    pulse_start();
    wait_idle();
    repeat (10) @(negedge clk);
    chk(n_conv == 2, "R10", n_conv, 2);
    chk(busy == 0, "R10", busy, 0);
    // continuous frames
    base = n_conv;
    @(negedge clk) cont = 1;
    repeat (4) @(posedge conv);
    @(negedge clk) cont = 0;
    wait_idle();
    repeat (5) @(negedge clk);
    chk(n_conv == base + 4, "R9", n_conv, base + 4);
    chk(q.size() == 0, "R7", q.size(), 0);
    done = 1;
  end
endmodule

// File: tb/sadc_reader_tb.sv
module sadc_reader_tb;
  logic clk = 0;
  logic rst_n = 0;
  int   c14, e14, c12, e12;
  logic d14, d12;
  bit   timeout = 0;

  always #5 clk = ~clk;

  sadc_reader_env #(.RES_BITS(14)) u_env14 (.clk(clk), .rst_n(rst_n), .checks(c14), .errors(e14), .done(d14));
  sadc_reader_env #(.RES_BITS(12)) u_env12 (.clk(clk), .rst_n(rst_n), .checks(c12), .errors(e12), .done(d12));

  initial begin
    int nchk, nerr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      wait (d14 === 1'b1 && d12 === 1'b1);
      begin
        repeat (20000) @(posedge clk);
        timeout = 1;
      end
    join_any
    nchk = c14 + c12;
    nerr = e14 + e12;
    if (timeout) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule